// File: doc/BRIEF.md
# Control word majority-vote decoder

This block sits on the receive side of a DC-balanced serial video link. It takes recovered, word-aligned 20-bit words together with a valid strobe and a phase code (control, video or transition). From each valid control word it rebuilds the 9-bit control bus. Five of the control bits arrive as three copies each, and each is resolved by a two-of-three vote, so one corrupted copy does not reach the output. This matters most for sync-type signals. The other four control bits arrive as a single copy each and pass straight through.

Outside the control phase the control bus keeps its last recovered value. Video and transition words leave it untouched. When any protected bit of an accepted control word arrives with copies that disagree, the block raises a one-cycle pulse. Downstream logic can count these pulses as corrected link errors.

Top module: `ctl_vote_decoder`

## Requirements
- R1: While reset is asserted and after its release until the first accepted word, `ctl_o` is all zeros and `fix_pulse_o` is low.
- R2: In an accepted word, protected output bit k (k = 0..4) is taken from word bits 3k+1, 3k+2 and 3k+3. For example, output bit 0 uses bits 1..3 and output bit 4 uses bits 13..15.
- R3: Each protected output bit takes the value held by at least two of its three copies. This includes the case where two copies were flipped and the output follows them.
- R4: A word in which exactly one copy of one triplet is inverted produces the same `ctl_o` as the same word with that triplet unanimous.
- R5: Output bits 5, 6, 7 and 8 equal word bits 16, 17, 18 and 19 of the accepted word, with no voting.
- R6: A word is accepted when `word_vld_i` is high and `phase_i` is 2'b00 (control). Its decoded value appears on `ctl_o` one clock later, and back-to-back control words update on every cycle.
- R7: `ctl_o` keeps its value in a cycle with `word_vld_i` low or with `phase_i` equal to 2'b01 (video), 2'b10 (transition) or the unused code 2'b11.
- R8: `fix_pulse_o` is high for exactly the one cycle after an accepted word in which at least one triplet is not unanimous. It is low after every other cycle, including after video and transition words.
- R9: Word bit 0, the overhead bit, has no effect on `ctl_o` or `fix_pulse_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_i | input | 20 | Recovered, aligned serial word; bit 0 is the first bit on the line |
| word_vld_i | input | 1 | Marks a valid word on `word_i` |
| phase_i | input | 2 | Phase of the word: 00 control, 01 video, 10 transition, 11 unused |
| ctl_o | output | 9 | Recovered control bus, held between control words |
| fix_pulse_o | output | 1 | One-cycle flag that the last accepted word had a non-unanimous triplet |

## Verification
The assertions assume that `word_vld_i`, `phase_i` and `word_i` are driven to known values in every clocked cycle after reset and change only between clock edges. The vote and pass-through checks assume that a word which is not in the control phase may carry any bit pattern. The stimulus meets these assumptions by driving every input on the falling edge only, always from defined values. It also mixes arbitrary video-, transition- and unused-phase words between the control words so that the hold behaviour is exercised with garbage on the data lines.

// File: rtl/ctlv_pkg.sv
package ctlv_pkg;

   typedef enum logic [1:0] {
      PH_CTRL  = 2'b00,
      PH_VIDEO = 2'b01,
      PH_TRANS = 2'b10,
      PH_RSVD  = 2'b11
   } ctlv_phase_e;

   localparam int unsigned CTLV_PHASE_W = 2;

endpackage

// File: rtl/ctlv_vote3.sv
module ctlv_vote3 #(
   parameter int unsigned COPIES = 3
) (
   input  logic [COPIES-1:0] copies_i,
   output logic              bit_o,
   output logic              split_o
);

   localparam int unsigned QUORUM = (COPIES + 1) / 2;

   generate
      if (COPIES < 3 || (COPIES % 2) == 0) begin : g_bad
         $error("ctlv_vote3: COPIES must be odd and at least 3");
      end

      if (COPIES == 3) begin : g_tmr
         always_comb begin
            bit_o   = (copies_i[0] & copies_i[1]) |
                      (copies_i[0] & copies_i[2]) |
                      (copies_i[1] & copies_i[2]);
            split_o = (copies_i[0] ^ copies_i[1]) | (copies_i[1] ^ copies_i[2]);
         end
      end else begin : g_wide
         always_comb begin
            bit_o   = ($countones(copies_i) >= QUORUM);
            split_o = (|copies_i) & ~(&copies_i);
         end
      end
   endgenerate

endmodule

// File: rtl/ctlv_unpack.sv
module ctlv_unpack #(
   parameter int unsigned N_PROT = 5,
   parameter int unsigned N_RAW  = 4,
   parameter int unsigned COPIES = 3,
   localparam int unsigned BODY_W   = N_PROT * COPIES + N_RAW,
   localparam int unsigned RAW_BASE = N_PROT * COPIES
) (
   input  logic [BODY_W-1:0]              body_i,
   output logic [N_PROT-1:0][COPIES-1:0]  trip_o,
   output logic [N_RAW-1:0]               raw_o
);

   generate
      for (genvar k = 0; k < N_PROT; k++) begin : g_trip
         assign trip_o[k] = body_i[k*COPIES +: COPIES];
      end
      for (genvar r = 0; r < N_RAW; r++) begin : g_raw
         assign raw_o[r] = body_i[RAW_BASE + r];
      end
   endgenerate

endmodule

// File: rtl/ctlv_capture.sv
module ctlv_capture #(
   parameter int unsigned CTL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CTL_W-1:0] ctl_d_i,
   input  logic             split_i,
   output logic [CTL_W-1:0] ctl_o,
   output logic             pulse_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_o   <= '0;
         pulse_o <= 1'b0;
      end else begin
         pulse_o <= load_i & split_i;
         if (load_i) begin
            ctl_o <= ctl_d_i;
         end
      end
   end

endmodule

// File: rtl/ctl_vote_decoder.sv
module ctl_vote_decoder
   import ctlv_pkg::*;
#(
   parameter int unsigned WORD_W    = 20,
   parameter int unsigned N_PROT    = 5,
   parameter int unsigned N_RAW     = 4,
   parameter int unsigned COPIES    = 3,
   parameter int unsigned FIRST_BIT = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [WORD_W-1:0]         word_i,
   input  logic                      word_vld_i,
   input  logic [CTLV_PHASE_W-1:0]   phase_i,
   output logic [N_PROT+N_RAW-1:0]   ctl_o,
   output logic                      fix_pulse_o
);

   localparam int unsigned CTL_W  = N_PROT + N_RAW;
   localparam int unsigned BODY_W = N_PROT * COPIES + N_RAW;

   generate
      if (WORD_W != FIRST_BIT + BODY_W) begin : g_bad_width
         $error("ctl_vote_decoder: WORD_W does not match the field layout");
      end
      if (N_PROT == 0) begin : g_bad_prot
         $error("ctl_vote_decoder: N_PROT must be at least 1");
      end
   endgenerate

   logic [N_PROT-1:0][COPIES-1:0] trip;
   logic [N_RAW-1:0]              raw;
   logic [N_PROT-1:0]             voted;
   logic [N_PROT-1:0]             split;
   logic [CTL_W-1:0]              ctl_d;
   logic                          accept;

   ctlv_unpack #(
      .N_PROT (N_PROT),
      .N_RAW  (N_RAW),
      .COPIES (COPIES)
   ) u_unpack (
      .body_i (word_i[FIRST_BIT +: BODY_W]),
      .trip_o (trip),
      .raw_o  (raw)
   );

   generate
      for (genvar k = 0; k < N_PROT; k++) begin : g_vote
         ctlv_vote3 #(
            .COPIES (COPIES)
         ) u_vote (
            .copies_i (trip[k]),
            .bit_o    (voted[k]),
            .split_o  (split[k])
         );
      end
   endgenerate

   always_comb begin
      accept = word_vld_i && (ctlv_phase_e'(phase_i) == PH_CTRL);
      ctl_d  = {raw, voted};
   end

   ctlv_capture #(
      .CTL_W (CTL_W)
   ) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .ctl_d_i (ctl_d),
      .split_i (|split),
      .ctl_o   (ctl_o),
      .pulse_o (fix_pulse_o)
   );

endmodule

// File: rtl/ctl_vote_decoder_chk.sv
module ctl_vote_decoder_chk #(
   parameter int unsigned WORD_W    = 20,
   parameter int unsigned N_PROT    = 5,
   parameter int unsigned N_RAW     = 4,
   parameter int unsigned COPIES    = 3,
   parameter int unsigned FIRST_BIT = 1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [WORD_W-1:0]       word_i,
   input logic                    word_vld_i,
   input logic [1:0]              phase_i,
   input logic [N_PROT+N_RAW-1:0] ctl_o,
   input logic                    fix_pulse_o
);

   localparam int unsigned RAW_LSB = FIRST_BIT + N_PROT * COPIES;

   function automatic logic all_agree(input logic [WORD_W-1:0] w);
      logic ok;
      ok = 1'b1;
      for (int k = 0; k < N_PROT; k++) begin
         if (!((w[FIRST_BIT + k*COPIES +: COPIES] == '0) ||
               (w[FIRST_BIT + k*COPIES +: COPIES] == '1))) begin
            ok = 1'b0;
         end
      end
      return ok;
   endfunction

   logic take;
   assign take = word_vld_i && (phase_i == 2'b00);

   AST_RESET_ZERO: assert property (@(posedge clk)
      !rst_n |=> (ctl_o == '0 && !fix_pulse_o)); // R1

   AST_HOLD_OFF_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(ctl_o)); // R7

   AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (ctl_o[N_PROT +: N_RAW] == $past(word_i[RAW_LSB +: N_RAW]))); // R5

   AST_VOTE_ALL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (take && word_i[FIRST_BIT +: COPIES] == '1) |=> ctl_o[0]); // R3

   AST_VOTE_ALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (take && word_i[FIRST_BIT +: COPIES] == '0) |=> !ctl_o[0]); // R3

   AST_PULSE_NEEDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> !fix_pulse_o); // R8

   AST_NO_PULSE_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      (take && all_agree(word_i)) |=> !fix_pulse_o); // R8

   AST_PULSE_ON_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !all_agree(word_i)) |=> fix_pulse_o); // R8

endmodule

bind ctl_vote_decoder ctl_vote_decoder_chk #(
   .WORD_W    (WORD_W),
   .N_PROT    (N_PROT),
   .N_RAW     (N_RAW),
   .COPIES    (COPIES),
   .FIRST_BIT (FIRST_BIT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .word_i      (word_i),
   .word_vld_i  (word_vld_i),
   .phase_i     (phase_i),
   .ctl_o       (ctl_o),
   .fix_pulse_o (fix_pulse_o)
);

// File: tb/ctl_vote_decoder_tb.sv
`timescale 1ns/1ps
module ctl_vote_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] word = '0;
   logic        vld = 1'b0;
   logic [1:0]  phase = 2'b00;
   logic [8:0]  ctl;
   logic        pulse;

   int   n_run  = 0;
   int   n_fail = 0;
   logic [8:0] exp_ctl   = '0;
   logic       exp_pulse = 1'b0;
   string      last_tag  = "R1";

   always #10 clk = ~clk;

   ctl_vote_decoder u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .word_i      (word),
      .word_vld_i  (vld),
      .phase_i     (phase),
      .ctl_o       (ctl),
      .fix_pulse_o (pulse)
   );

   task automatic check_now(input string tag);
      n_run++;
      if (ctl !== exp_ctl || pulse !== exp_pulse) begin
         n_fail++;
         $display("FAIL %s: ctl=%h pulse=%b expected ctl=%h pulse=%b",
                  tag, ctl, pulse, exp_ctl, exp_pulse);
      end
   endtask

   // behavioural reference: counts copies, no gate structure
   task automatic model(input logic [19:0] w, input logic v, input logic [1:0] ph);
      logic [8:0] nc;
      logic       dis;
      if (v && ph == 2'b00) begin
         dis = 1'b0;
         for (int k = 0; k < 5; k++) begin
            int cnt;
            cnt = 0;
            for (int j = 0; j < 3; j++) cnt += w[1 + 3*k + j];
            nc[k] = (cnt >= 2);
            if (cnt == 1 || cnt == 2) dis = 1'b1;
         end
         for (int r = 0; r < 4; r++) nc[5+r] = w[16+r];
         exp_ctl   = nc;
         exp_pulse = dis;
      end else begin
         exp_pulse = 1'b0;
      end
   endtask

   task automatic step(input logic [19:0] w, input logic v, input logic [1:0] ph,
                       input string tag);
      @(negedge clk);
      check_now(last_tag);
      word  = w;
      vld   = v;
      phase = ph;
      model(w, v, ph);
      last_tag = tag;
   endtask

   function automatic logic [19:0] mk(input logic [4:0] prot, input logic [3:0] raw,
                                      input logic [14:0] flip, input logic b0);
      logic [19:0] w;
      w[0] = b0;
      for (int k = 0; k < 5; k++)
         for (int j = 0; j < 3; j++)
            w[1 + 3*k + j] = prot[k] ^ flip[3*k + j];
      for (int r = 0; r < 4; r++) w[16+r] = raw[r];
      return w;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [4:0] pv [3];
      pv[0] = 5'h00; pv[1] = 5'h1F; pv[2] = 5'h0A;

      // R1: reset state, with busy inputs
      word = 20'hFFFFF; vld = 1'b1;
      repeat (3) begin @(negedge clk); check_now("R1"); end
      rst_n = 1'b1; vld = 1'b0;
      @(negedge clk); check_now("R1");

      // R2: each protected bit alone
      for (int k = 0; k < 5; k++) step(mk(5'(1 << k), 4'h0, '0, 1'b0), 1'b1, 2'b00, "R2");

      // R4 / R8: single flipped copy, every position
      foreach (pv[i])
         for (int p = 0; p < 15; p++)
            step(mk(pv[i], 4'h5, 15'(1 << p), 1'b0), 1'b1, 2'b00, "R4");

      // R3: two copies flipped, output follows them
      for (int k = 0; k < 5; k++) begin
         step(mk(5'h00, 4'h0, 15'(3 << (3*k)), 1'b0), 1'b1, 2'b00, "R3");
         step(mk(5'h1F, 4'hF, 15'(5 << (3*k)), 1'b0), 1'b1, 2'b00, "R3");
      end

      // R5: unprotected bits pass through
      for (int r = 0; r < 16; r++) step(mk(5'h15, 4'(r), '0, 1'b1), 1'b1, 2'b00, "R5");

      // R9: overhead bit toggled
      step(mk(5'h0C, 4'h9, '0, 1'b0), 1'b1, 2'b00, "R9");
      step(mk(5'h0C, 4'h9, '0, 1'b1), 1'b1, 2'b00, "R9");
      step(mk(5'h0C, 4'h9, 15'h0010, 1'b1), 1'b1, 2'b00, "R9");

      // R7: hold across other phases and invalid cycles
      step(mk(5'h13, 4'h6, '0, 1'b0), 1'b1, 2'b00, "R6");
      step(20'hFFFFF, 1'b1, 2'b01, "R7");
      step(20'h5A5A5, 1'b1, 2'b10, "R7");
      step(20'hA5A5A, 1'b1, 2'b11, "R7");
      step(20'h00000, 1'b0, 2'b00, "R7");
      step(20'h0F0F0, 1'b0, 2'b01, "R7");

      // R6: back-to-back control words
      for (int n = 0; n < 8; n++)
         step(n[0] ? 20'hFFFFF : 20'h00000, 1'b1, 2'b00, "R6");

      // mixed traffic
      for (int n = 0; n < 400; n++)
         step(20'($urandom), ($urandom % 4) != 0, 2'($urandom), "R6");

      step('0, 1'b0, 2'b01, "R7");
      @(negedge clk); check_now(last_tag);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule